// File: doc/BRIEF.md
# Routed 32-Line Interrupt Controller

This block collects thirty-two external interrupt lines and presents them to a processor as two request pins: a normal request (`irq`) and a fast request (`fiq`). Each line passes through a two-flop synchronizer. A per-line sense bit then corrects its polarity. A rising edge of the corrected level latches a pending request. Software configures and services the lines through a small word-addressed register port. Writes take effect on the clock edge that samples `wr_en`. A read strobe returns its data on the next edge.

Software picks, line by line, whether a request goes to the normal or the fast pin, and which lines may reach a pin at all. It can inspect the corrected live levels and the enabled requests on each pin. It can drop pending requests with a write-one clear, and raise them with a write-one set. The set register is how a level-style source is serviced: after clearing a line whose input is still asserted, software re-raises it by writing its bit to the set register.

Top module: `intc_core`

## Requirements
- R1: After reset every register reads 0, and `irq` and `fiq` are low: no line enabled, all lines active-high, all routed to the normal pin, nothing pending.
- R2: Word address 1 holds the sense bits, where 1 means active-low. Address 5 reads each synchronized input XOR its sense bit, so a 1 means "asserted".
- R3: A pending bit is set by a 0-to-1 change of the corrected level. After an input changes, the effect appears after the third rising clock edge. A level held asserted does not set the bit again once it has been cleared.
- R4: Writing to address 3 clears each pending bit written as 1. Pending bits written as 0 keep their value.
- R5: Writing to address 4 sets each pending bit written as 1. A new edge on a line beats a clear of that line written on the same cycle.
- R6: Address 2 is the enable word. A pending bit whose enable is 0 reaches neither pin nor either request register, but it stays pending and appears once it is enabled.
- R7: Address 0 holds the route bits (1 = fast pin, 0 = normal pin). Address 6 reads pending & enable & ~route, and `irq` is its OR. Address 7 reads pending & enable & route, and `fiq` is its OR.
- R8: Addresses 0, 1 and 2 read back the value last written. Addresses 3 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Raw asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears after the next edge |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Normal interrupt request to the processor |
| fiq | output | 1 | Fast interrupt request to the processor |

## Verification
The bench builds the block with its default values: 32 lines and a two-stage synchronizer. This puts both halves of the route word and both halves of the sense word within reach of each test. At these values the three-edge input latency is short enough to land a clear write on exactly the cycle in which a new edge arrives. This tests the edge-over-clear priority and the cycle-exact latency on the pins.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ROUTE = 3'd0,
    A_SENSE = 3'd1,
    A_EN    = 3'd2,
    A_CLR   = 3'd3,
    A_SET   = 3'd4,
    A_LIVE  = 3'd5,
    A_NREQ  = 3'd6,
    A_FREQ  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = d_in;
      end else begin : g_rest
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] clr_pls,
  input  logic [W-1:0] set_pls,
  output logic [W-1:0] live,
  output logic [W-1:0] pend
);
  logic [W-1:0] live_q;
  logic [W-1:0] rise;
  logic [W-1:0] pend_q, pend_d;

  always_comb begin
    live   = sync_in ^ sense;
    rise   = live & ~live_q;
    pend_d = (pend_q & ~clr_pls) | rise | set_pls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      pend_q <= '0;
    end else begin
      live_q <= live;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3: a corrected rising edge is pending on the next cycle
  a_r3_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(rise)) == $past(rise)));

  // R4: cleared lines without a fresh edge or set drop their request
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_pls & ~set_pls & ~rise)) == '0));

  // R4: a pending bit only falls when it was written to clear
  a_r4_hold_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~pend_q) & $past(pend_q) & ~$past(clr_pls)) == '0));

  // R5: a set write always leaves the bit pending
  a_r5_set_forces: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_pls)) == $past(set_pls)));
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      live,
  input  logic [W-1:0]      nreq,
  input  logic [W-1:0]      freq,
  output logic [W-1:0]      route,
  output logic [W-1:0]      sense,
  output logic [W-1:0]      enable,
  output logic [W-1:0]      clr_pls,
  output logic [W-1:0]      set_pls,
  output logic [W-1:0]      rdata
);
  reg_addr_e    sel;
  logic [W-1:0] route_q, route_d;
  logic [W-1:0] sense_q, sense_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] rd_q, rd_d;
  logic         route_we, sense_we, en_we;

  always_comb begin
    sel      = reg_addr_e'(addr);
    route_we = wr_en && (sel == A_ROUTE);
    sense_we = wr_en && (sel == A_SENSE);
    en_we    = wr_en && (sel == A_EN);
    clr_pls  = (wr_en && (sel == A_CLR)) ? wdata : '0;
    set_pls  = (wr_en && (sel == A_SET)) ? wdata : '0;

    route_d = route_we ? wdata : route_q;
    sense_d = sense_we ? wdata : sense_q;
    en_d    = en_we    ? wdata : en_q;

    rd_d = rd_q;
    if (rd_en) begin
      unique case (sel)
        A_ROUTE: rd_d = route_q;
        A_SENSE: rd_d = sense_q;
        A_EN:    rd_d = en_q;
        A_LIVE:  rd_d = live;
        A_NREQ:  rd_d = nreq;
        A_FREQ:  rd_d = freq;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      sense_q <= '0;
      en_q    <= '0;
      rd_q    <= '0;
    end else begin
      route_q <= route_d;
      sense_q <= sense_d;
      en_q    <= en_d;
      rd_q    <= rd_d;
    end
  end

  assign route  = route_q;
  assign sense  = sense_q;
  assign enable = en_q;
  assign rdata  = rd_q;

  // R8: a configuration word holds its value between writes to it
  a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (sel inside {A_ROUTE, A_SENSE, A_EN})) |=>
      ($stable(route_q) && $stable(sense_q) && $stable(en_q)));
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  output logic              irq,
  output logic              fiq
);
  logic [1:0]       rst_sh_q;
  logic             rst_s_n;
  logic [N_SRC-1:0] sync_lvl, live, pend;
  logic [N_SRC-1:0] route, sense, enable, clr_pls, set_pls;
  logic [N_SRC-1:0] nreq, freq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  intc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d_in(irq_in), .d_out(sync_lvl)
  );

  intc_pend #(.W(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_s_n), .sync_in(sync_lvl), .sense(sense),
    .clr_pls(clr_pls), .set_pls(set_pls), .live(live), .pend(pend)
  );

  intc_regs #(.W(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .live(live), .nreq(nreq), .freq(freq), .route(route),
    .sense(sense), .enable(enable), .clr_pls(clr_pls), .set_pls(set_pls),
    .rdata(rdata)
  );

  always_comb begin
    nreq = pend & enable & ~route;
    freq = pend & enable & route;
    irq  = |nreq;
    fiq  = |freq;
  end

  // R6: with every line disabled neither pin can be driven
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (enable == '0) |-> (!irq && !fiq));

  // R7: a request raised by the fast pin never comes from a normal-routed line
  a_r7_fast_routed: assert property (@(posedge clk) disable iff (!rst_s_n)
    fiq |-> ((pend & route) != '0));
endmodule

// File: tb/sim_intc_core.sv
module sim_intc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_tot = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [2:0]  a;
    logic [31:0] e;
    string       tag;
  } item_t;
  item_t exp_q[$];
  logic  rd_seen = 1'b0;

  always #4 clk = ~clk;

  intc_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .fiq(fiq)
  );

  // monitor: pops an expected item for every read the design returns
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      if (exp_q.size() == 0) begin
        n_tot++; n_bad++;
        $display("FAIL scoreboard empty: unexpected read data %h", rdata);
      end else begin
        it = exp_q.pop_front();
        n_tot++;
        if (rdata !== it.e) begin
          n_bad++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rdata, it.e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.a = a; it.e = e; it.tag = tag;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pin_chk(input logic ei, input logic ef, input string tag);
    n_tot++;
    if (irq !== ei || fiq !== ef) begin
      n_bad++;
      $display("FAIL %s pins actual irq=%b fiq=%b expected irq=%b fiq=%b",
               tag, irq, fiq, ei, ef);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog expired, run hung (all requirements)");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    pin_chk(1'b0, 1'b0, "R1 reset pins");
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1 reset register");

    // R8: readback of configuration words, write-one words read 0
    wr(3'd0, 32'hFFFF_0000);
    wr(3'd1, 32'h0000_00FF);
    idle(4);
    wr(3'd3, 32'hFFFF_FFFF);       // drop edges caused by the sense change
    rd_chk(3'd0, 32'hFFFF_0000, "R8 route readback");
    rd_chk(3'd1, 32'h0000_00FF, "R8 sense readback");
    rd_chk(3'd2, 32'h0, "R8 enable readback");
    rd_chk(3'd3, 32'h0, "R8 clear reads zero");
    rd_chk(3'd4, 32'h0, "R8 set reads zero");

    // R2: live level is synchronized input XOR sense
    irq_in = 32'h0000_0101;
    idle(4);
    rd_chk(3'd5, 32'h0000_01FE, "R2 live level");
    rd_chk(3'd6, 32'h0, "R6 pending hidden while disabled");
    pin_chk(1'b0, 1'b0, "R6 pins quiet while disabled");

    // R6/R7: enabling reveals the stored edge on the normal pin
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk(3'd2, 32'hFFFF_FFFF, "R8 enable readback");
    rd_chk(3'd6, 32'h0000_0100, "R6 pending kept across disable");
    rd_chk(3'd7, 32'h0, "R7 nothing on fast path");
    pin_chk(1'b1, 1'b0, "R7 normal pin");

    // R3: held level does not re-raise after clear
    wr(3'd3, 32'h0000_0100);
    idle(3);
    rd_chk(3'd6, 32'h0, "R3 held level no re-raise");
    pin_chk(1'b0, 1'b0, "R3 pins after clear");

    // R5 set, R4 partial clear
    wr(3'd4, 32'h0000_0300);
    rd_chk(3'd6, 32'h0000_0300, "R5 set raises");
    wr(3'd3, 32'h0000_0100);
    rd_chk(3'd6, 32'h0000_0200, "R4 zero bits unaffected");
    wr(3'd3, 32'h0000_0200);
    rd_chk(3'd6, 32'h0, "R4 clear drops");

    // R7: fast routing
    wr(3'd4, 32'h0001_0000);
    rd_chk(3'd7, 32'h0001_0000, "R7 fast request");
    rd_chk(3'd6, 32'h0, "R7 not on normal path");
    pin_chk(1'b0, 1'b1, "R7 fast pin");
    wr(3'd3, 32'h0001_0000);
    pin_chk(1'b0, 1'b0, "R4 fast cleared");

    // R6: disable gates a set request, re-enable shows it
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h0000_0008);
    rd_chk(3'd6, 32'h0, "R6 disabled hidden");
    pin_chk(1'b0, 1'b0, "R6 disabled pins");
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk(3'd6, 32'h0000_0008, "R6 re-enabled visible");
    wr(3'd3, 32'h0000_0008);

    // R5: edge beats a clear landing on the same edge
    @(negedge clk); irq_in[12] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd3; wdata = 32'h0000_1000;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk(3'd6, 32'h0000_1000, "R5 edge over clear");
    wr(3'd3, 32'h0000_1000);

    // R2/R3: active-low line, latency of three edges
    @(negedge clk); irq_in[3] = 1'b1;   // deasserts an active-low line
    idle(4);
    rd_chk(3'd6, 32'h0, "R2 active-low deassert no request");
    @(negedge clk); irq_in[3] = 1'b0;   // asserts it
    @(negedge clk);
    @(negedge clk);
    pin_chk(1'b0, 1'b0, "R3 not yet after two edges");
    @(negedge clk);
    pin_chk(1'b1, 1'b0, "R3 pending after third edge");
    rd_chk(3'd6, 32'h0000_0008, "R2 active-low edge");

    idle(3);
    if (exp_q.size() != 0) begin
      n_tot++; n_bad++;
      $display("FAIL scoreboard left %0d items (R8) actual=%0d expected=0",
               exp_q.size(), exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule